// File: doc/BRIEF.md
# Readout Controller Event Interface

This block sits in each readout crate and receives the event identifier that a central generator sends over a parallel link. A 16-bit word comes with a strobe. The block brings both into the local clock domain and captures the word. It then raises a busy line back to the generator and presents the event number and type to local readout logic. Busy stays high until local logic acknowledges that the event data is safely buffered.

The captured type is decoded into normal or special. An event-number continuity monitor flags gaps, and an overrun flag records strobes that arrive while the interface is still busy. On request from the local processor, the block runs a pedestal preparation sequence. It holds busy, switches zero suppression off, releases busy, and then fires a one-cycle pulser output. Zero suppression returns to on once the resulting pedestal event has been acknowledged.

Top module: `evt_rx_if`

## Requirements
- R1: A rising edge of `link_strobe_i` that is first sampled high at clock edge k, with `link_word_i` stable from before k, is captured at edge k+2 if the interface is not busy. From that edge `evt_valid_o` and `busy_o` are high.
- R2: `buffered_i` high at a clock edge while `evt_valid_o` is high clears `evt_valid_o` at that edge, and `busy_o` drops with it unless a pedestal sequence holds it. `buffered_i` while no event is held has no effect.
- R3: The event number output carries captured word bits 11:0, and the type output carries bits 15:12.
- R4: `evt_special_o` is high exactly when the captured type is nonzero. Type 0000 is a normal event.
- R5: A `ped_req_i` accepted at edge e sets `busy_o` from e to e+2. `zs_enable_o` falls at e+1. `busy_o` is released at e+2. `pulser_o` is high for the single cycle following edge e+3.
- R6: `zs_enable_o` is high after reset. It returns high at the edge where an event of type 1000 is acknowledged through `buffered_i`.
- R7: `seq_err_o` is held with each captured event. It is high when the event number differs from the previous captured number plus one, modulo 4096. The first event after reset and events of type 1111 never flag it, and every captured event becomes the new previous number.
- R8: A synchronized strobe edge arriving while `busy_o` is high sets the sticky `overrun_o` at the edge where a capture would have happened. The held event outputs stay unchanged.
- R9: `ped_req_i` is ignored while an event is held, while a sequence is running, or at an edge where a strobe capture occurs.
- R10: After reset, `busy_o`, `evt_valid_o`, `pulser_o`, `seq_err_o`, `overrun_o` and the event fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_word_i | input | 16 | Event word from the generator (asynchronous) |
| link_strobe_i | input | 1 | Word strobe from the generator (asynchronous) |
| buffered_i | input | 1 | Local logic acknowledges the event data is buffered |
| ped_req_i | input | 1 | Local processor requests a pedestal sequence |
| busy_o | output | 1 | Busy back to the generator |
| evt_valid_o | output | 1 | A captured event is held |
| evt_num_o | output | 12 | Captured event number |
| evt_type_o | output | 4 | Captured event type |
| evt_special_o | output | 1 | Captured type needs local action |
| seq_err_o | output | 1 | Captured number breaks continuity |
| overrun_o | output | 1 | Sticky: strobe received while busy |
| zs_enable_o | output | 1 | Zero-suppression enable level |
| pulser_o | output | 1 | One-cycle pedestal pulser fire |

## Verification
The continuity monitor has state that the ports never show directly. A corrupted previous number only becomes visible on the next captured event, as a wrong `seq_err_o`. The bench therefore sends runs with a deliberate gap, a wraparound from 4095 to 0, and a sync event in the middle. A wrong pedestal sequencer state shows at the ports within one to four cycles, as a misplaced busy, zero-suppression or pulser edge. A wrong capture path shows two cycles after the strobe, as shifted or overwritten event fields. The bench compares every output to its model on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/evt_rx_pkg.sv
package evt_rx_pkg;

  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_HOLD  = 3'd1,
    PS_ZSOFF = 3'd2,
    PS_REL   = 3'd3,
    PS_FIRE  = 3'd4
  } ped_state_t;

endpackage

// File: rtl/evt_rx_sync.sv
module evt_rx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         strobe_i,
  output logic [W-1:0] word_o,
  output logic         edge_o
);

  logic [STAGES-1:0] stb_q;
  logic [W-1:0]      wd_q [STAGES];
  logic              stb_last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stb_q[0] <= 1'b0;
            wd_q[0]  <= '0;
          end else begin
            stb_q[0] <= strobe_i;
            wd_q[0]  <= word_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stb_q[g] <= 1'b0;
            wd_q[g]  <= '0;
          end else begin
            stb_q[g] <= stb_q[g-1];
            wd_q[g]  <= wd_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_last_q <= 1'b0;
    else        stb_last_q <= stb_q[STAGES-1];
  end

  assign edge_o = stb_q[STAGES-1] & ~stb_last_q;
  assign word_o = wd_q[STAGES-1];

endmodule

// File: rtl/evt_rx_ped.sv
module evt_rx_ped
  import evt_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic start_ok_i,
  input  logic restore_i,
  output logic hold_o,
  output logic zs_en_o,
  output logic pulse_o
);

  ped_state_t state_q, state_d;
  logic       zs_q, zs_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:  if (req_i && start_ok_i) state_d = PS_HOLD;
      PS_HOLD:  state_d = PS_ZSOFF;
      PS_ZSOFF: state_d = PS_REL;
      PS_REL:   state_d = PS_FIRE;
      PS_FIRE:  state_d = PS_IDLE;
      default:  state_d = PS_IDLE;
    endcase
  end

  always_comb begin
    zs_d = zs_q;
    if (state_q == PS_HOLD) zs_d = 1'b0;
    else if (restore_i)     zs_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      zs_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      zs_q    <= zs_d;
    end
  end

  assign hold_o  = (state_q == PS_HOLD) || (state_q == PS_ZSOFF);
  assign pulse_o = (state_q == PS_FIRE);
  assign zs_en_o = zs_q;

  AST_PULSE_ZS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> !zs_en_o); // R5
  AST_HOLD_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !zs_en_o && $past(hold_o)) |=> !hold_o); // R5

endmodule

// File: rtl/evt_rx_if.sv
module evt_rx_if #(
  parameter int                NUM_W       = 12,
  parameter int                TYPE_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [TYPE_W-1:0] PED_TYPE    = 4'h8,
  parameter logic [TYPE_W-1:0] SYNC_TYPE   = 4'hF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_W+TYPE_W-1:0]  link_word_i,
  input  logic                     link_strobe_i,
  input  logic                     buffered_i,
  input  logic                     ped_req_i,
  output logic                     busy_o,
  output logic                     evt_valid_o,
  output logic [NUM_W-1:0]         evt_num_o,
  output logic [TYPE_W-1:0]        evt_type_o,
  output logic                     evt_special_o,
  output logic                     seq_err_o,
  output logic                     overrun_o,
  output logic                     zs_enable_o,
  output logic                     pulser_o
);

  localparam int WORD_W = NUM_W + TYPE_W;

  logic [WORD_W-1:0] word_s;
  logic              edge_s;
  logic              ped_hold;

  logic              valid_q, valid_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic              err_q, err_d;
  logic              ovr_q, ovr_d;
  logic [NUM_W-1:0]  prev_q, prev_d;
  logic              have_prev_q, have_prev_d;

  logic              busy;
  logic              capture;
  logic              release_evt;
  logic [NUM_W-1:0]  in_num;
  logic [TYPE_W-1:0] in_type;

  evt_rx_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_i   (link_word_i),
    .strobe_i (link_strobe_i),
    .word_o   (word_s),
    .edge_o   (edge_s)
  );

  assign busy        = valid_q | ped_hold;
  assign capture     = edge_s & ~busy;
  assign release_evt = valid_q & buffered_i;
  assign in_num      = word_s[NUM_W-1:0];
  assign in_type     = word_s[WORD_W-1:NUM_W];

  evt_rx_ped u_ped (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (ped_req_i),
    .start_ok_i (~valid_q & ~edge_s),
    .restore_i  (release_evt && (type_q == PED_TYPE)),
    .hold_o     (ped_hold),
    .zs_en_o    (zs_enable_o),
    .pulse_o    (pulser_o)
  );

  always_comb begin
    valid_d     = valid_q;
    num_d       = num_q;
    type_d      = type_q;
    err_d       = err_q;
    ovr_d       = ovr_q;
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    if (edge_s && busy) ovr_d = 1'b1;
    if (release_evt) valid_d = 1'b0;
    if (capture) begin
      valid_d     = 1'b1;
      num_d       = in_num;
      type_d      = in_type;
      err_d       = have_prev_q && (in_type != SYNC_TYPE) &&
                    (in_num != prev_q + 1'b1);
      prev_d      = in_num;
      have_prev_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      num_q       <= '0;
      type_q      <= '0;
      err_q       <= 1'b0;
      ovr_q       <= 1'b0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      valid_q     <= valid_d;
      num_q       <= num_d;
      type_q      <= type_d;
      err_q       <= err_d;
      ovr_q       <= ovr_d;
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
    end
  end

  assign busy_o        = busy;
  assign evt_valid_o   = valid_q;
  assign evt_num_o     = num_q;
  assign evt_type_o    = type_q;
  assign evt_special_o = |type_q;
  assign seq_err_o     = err_q;
  assign overrun_o     = ovr_q;

  AST_CAPTURE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_s && !busy_o) |=> (evt_valid_o && busy_o)); // R1
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && buffered_i) |=> !evt_valid_o); // R2
  AST_OVERRUN_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_s && evt_valid_o && !buffered_i) |=> (overrun_o && $stable(evt_num_o) && $stable(evt_type_o))); // R8
  AST_SYNC_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_type_o == SYNC_TYPE) |-> !seq_err_o); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R8

endmodule

// File: tb/evt_rx_if_tb.sv
`timescale 1ns/1ps
module evt_rx_if_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] link_word;
  logic        link_strobe;
  logic        buffered;
  logic        ped_req;
  logic        busy, evt_valid, evt_special, seq_err, overrun, zs_enable, pulser;
  logic [11:0] evt_num;
  logic [3:0]  evt_type;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evt_rx_if u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_word_i   (link_word),
    .link_strobe_i (link_strobe),
    .buffered_i    (buffered),
    .ped_req_i     (ped_req),
    .busy_o        (busy),
    .evt_valid_o   (evt_valid),
    .evt_num_o     (evt_num),
    .evt_type_o    (evt_type),
    .evt_special_o (evt_special),
    .seq_err_o     (seq_err),
    .overrun_o     (overrun),
    .zs_enable_o   (zs_enable),
    .pulser_o      (pulser)
  );

  // behavioural reference model
  int m_stb_hist[$];
  int m_word_hist[$];
  int m_last_stb, m_valid, m_num, m_type, m_err, m_ovr, m_prev, m_have_prev;
  int m_zs, m_ped_cnt;  // m_ped_cnt: 0 idle, 1..4 cycles into sequence

  function automatic int m_busy();
    return (m_valid != 0 || m_ped_cnt == 1 || m_ped_cnt == 2) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_stb_hist = '{0, 0};
    m_word_hist = '{0, 0};
    m_last_stb = 0; m_valid = 0; m_num = 0; m_type = 0; m_err = 0;
    m_ovr = 0; m_prev = 0; m_have_prev = 0; m_zs = 1; m_ped_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int sync_stb, sync_word, edge_now, bsy, rel, ped_start;
      sync_stb  = m_stb_hist[1];
      sync_word = m_word_hist[1];
      edge_now  = (sync_stb == 1 && m_last_stb == 0) ? 1 : 0;
      bsy       = m_busy();
      rel       = (m_valid == 1 && buffered == 1'b1) ? 1 : 0;
      ped_start = (m_ped_cnt == 0 && ped_req && m_valid == 0 && edge_now == 0) ? 1 : 0;
      if (m_ped_cnt == 1) m_zs = 0;
      else if (rel == 1 && m_type == 8) m_zs = 1;
      if (m_ped_cnt != 0) m_ped_cnt = (m_ped_cnt == 4) ? 0 : m_ped_cnt + 1;
      else if (ped_start == 1) m_ped_cnt = 1;
      if (edge_now == 1 && bsy == 1) m_ovr = 1;
      if (rel == 1) m_valid = 0;
      if (edge_now == 1 && bsy == 0) begin
        int n, t;
        n = sync_word % 4096;
        t = sync_word / 4096;
        m_err = (m_have_prev == 1 && t != 15 && n != (m_prev + 1) % 4096) ? 1 : 0;
        m_valid = 1; m_num = n; m_type = t; m_prev = n; m_have_prev = 1;
      end
      m_last_stb = sync_stb;
      m_stb_hist = '{int'(link_strobe), m_stb_hist[0]};
      m_word_hist = '{int'(link_word), m_word_hist[0]};
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 busy", int'(busy), m_busy());
      chk("R2 evt_valid", int'(evt_valid), m_valid);
      chk("R3 evt_num", int'(evt_num), m_num);
      chk("R3 evt_type", int'(evt_type), m_type);
      chk("R4 special", int'(evt_special), (m_type != 0) ? 1 : 0);
      chk("R5 pulser", int'(pulser), (m_ped_cnt == 4) ? 1 : 0);
      chk("R6 zs_enable", int'(zs_enable), m_zs);
      chk("R7 seq_err", int'(seq_err), m_err);
      chk("R8 overrun", int'(overrun), m_ovr);
    end
  end

  task automatic send_word(logic [15:0] w);
    @(negedge clk);
    link_word = w; link_strobe = 1'b1;
    repeat (4) @(negedge clk);
    link_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); buffered = 1'b1;
    @(negedge clk); buffered = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pedestal();
    @(negedge clk); ped_req = 1'b1;
    @(negedge clk); ped_req = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; link_word = '0; link_strobe = 1'b0; buffered = 1'b0; ped_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 evt_valid", int'(evt_valid), 0);
    chk("R10 overrun", int'(overrun), 0);
    chk("R10 zs_enable", int'(zs_enable), 1);

    // R1 capture timing: strobe sampled high at edge k, outputs at k+2
    @(negedge clk);
    link_word = 16'h0000; link_strobe = 1'b1;
    @(posedge clk); #1; chk("R1 not yet k", int'(evt_valid), 0);
    @(posedge clk); #1; chk("R1 not yet k+1", int'(evt_valid), 0);
    @(posedge clk); #1; chk("R1 captured k+2", int'(evt_valid), 1);
    @(negedge clk); link_strobe = 1'b0;
    repeat (3) @(negedge clk);
    ack();
    chk("R2 released", int'(busy), 0);

    // R2 buffered with no event held: no effect
    ack();
    chk("R2 idle ack ignored", int'(evt_valid), 0);

    send_word(16'h0001); ack();
    send_word(16'h0003); chk("R7 gap flagged", int'(seq_err), 1); ack();
    send_word(16'h2004); chk("R4 special", int'(evt_special), 1); ack();
    send_word(16'hF064); chk("R7 sync exempt", int'(seq_err), 0); ack();
    send_word(16'h0065); chk("R7 after sync", int'(seq_err), 0); ack();

    // R5 pedestal sequence, R6 restore after pedestal-type event
    pedestal();
    repeat (4) @(negedge clk);
    chk("R5 zs off", int'(zs_enable), 0);
    chk("R5 busy released", int'(busy), 0);
    send_word(16'h8066);
    chk("R6 still off while held", int'(zs_enable), 0);
    ack();
    chk("R6 restored", int'(zs_enable), 1);

    // R9 pedestal request while event held is ignored
    send_word(16'h0067);
    pedestal();
    repeat (5) @(negedge clk);
    chk("R9 zs untouched", int'(zs_enable), 1);
    // R8 overrun: second strobe while busy
    send_word(16'h0ABC);
    chk("R8 overrun set", int'(overrun), 1);
    chk("R8 word kept", int'(evt_num), 16'h067);
    ack();

    // R7 wraparound 4095 -> 0
    send_word(16'h0FFF); ack();
    send_word(16'h0000); chk("R7 wrap ok", int'(seq_err), 0); ack();

    // R9 pedestal request on the capture edge
    @(negedge clk); link_word = 16'h0001; link_strobe = 1'b1;
    @(negedge clk); @(negedge clk); ped_req = 1'b1;
    @(negedge clk); ped_req = 1'b0; link_strobe = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 zs kept", int'(zs_enable), 1);
    ack();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule